// File: doc/BRIEF.md
# Parallel Adaptive Coefficient Update Array

This block adapts the taps of an adaptive FIR filter with the least-mean-square rule, one lane per tap, all lanes in the same clock cycle. Each lane takes its current tap weight, the reference sample that lines up with that tap, and one shared error sample. It adds the scaled product to the weight. The step size is a fixed power of two, applied as an arithmetic right shift, so no multiplier is spent on it. Results are clamped to the signed weight range.

The update runs in two steps, each with its own command. An update command (`mac_go`, gated by `mac_en`, sized by `mac_order`) computes the new weights into a staging register and pulses `upd_done`. A separate write-back command (`wr_go`, gated by `wr_en`, sized by `wr_order`) drives per-tap write strobes and data towards the external weight buffer, then pulses `wr_done`. The surrounding controller issues an update only after the convolution that produced the error sample. It issues write-back before the next convolution needs the new weights.

Top module: `coef_adapt_array`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `w_new` is all zero, `upd_done` and `wr_done` are low, and `wbuf_we` is all zero.
- R2: An update command (`mac_go` and `mac_en` high at a clock edge) sets each active lane i of `w_new` to w_i + floor(e·x_i / 2^SHIFT), where lane i occupies bits [i·DW +: DW] of each flat bus. The new values are visible after that edge, and `upd_done` is high for that one cycle.
- R3: When the sum leaves the signed DW-bit range, the lane holds 2^(DW-1)-1 on the positive side and -2^(DW-1) on the negative side. It never wraps.
- R4: A lane is active when its index is below `mac_order`. An inactive lane copies its `w_cur` value unchanged. An order above LANES activates every lane, and an order of zero activates none but still pulses `upd_done`.
- R5: `mac_go` with `mac_en` low has no effect: `upd_done` stays low and `w_new` keeps its value.
- R6: A write-back command (`wr_go` and `wr_en` high at an edge) raises `wbuf_we` bits [wr_order-1:0] (all bits when the order exceeds LANES) for exactly one cycle after that edge. `wbuf_wdata` then equals the staged weights, and `wr_done` is high for the following single cycle.
- R7: `wr_go` with `wr_en` low has no effect: `wbuf_we` stays zero and `wr_done` stays low.
- R8: When update and write-back commands land on the same edge, write-back carries the weights staged before that edge, and `w_new` takes the new result.
- R9: Each done pulse lasts one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_go | input | 1 | Update command strobe |
| mac_en | input | 1 | Update enable; command ignored when low |
| mac_order | input | OW | Number of lanes to update |
| x_win | input | LANES*DW | Reference window, lane i at [i*DW +: DW] |
| err_smp | input | DW | Shared error sample |
| w_cur | input | LANES*DW | Current weights read from the weight buffer |
| w_new | output | LANES*DW | Staged updated weights |
| upd_done | output | 1 | One-cycle pulse when an update has finished |
| wr_go | input | 1 | Write-back command strobe |
| wr_en | input | 1 | Write-back enable; command ignored when low |
| wr_order | input | OW | Number of lanes to write back |
| wbuf_we | output | LANES | Per-lane weight-buffer write strobes |
| wbuf_wdata | output | LANES*DW | Write data for the weight buffer |
| wr_done | output | 1 | One-cycle pulse when write-back has finished |

## Verification
An update and a write-back can be accepted on the same clock edge. The write-back reads the staging register while the update loads it. The bench first stages a known result. It then raises `mac_go` and `wr_go` together with a different input vector. It judges the pair by requiring that the strobed write data equal the earlier result, while `w_new` shows the newly computed one.

// File: rtl/coef_adapt_pkg.sv
package coef_adapt_pkg;
   // Rounding applied to the scaled error-times-reference product
   typedef enum logic {
      RND_FLOOR   = 1'b0,
      RND_NEAREST = 1'b1
   } rnd_e;
endpackage

// File: rtl/coef_order_mask.sv
module coef_order_mask #(
   parameter int LANES = 8,
   parameter int OW    = $clog2(LANES + 1)
) (
   input  logic [OW-1:0]    order,
   output logic [LANES-1:0] mask
);
   // Thermometer mask: lane g active when its index is below the order
   for (genvar g = 0; g < LANES; g++) begin : g_bit
      assign mask[g] = ({1'b0, order} > (OW+1)'(g));
   end
endmodule

// File: rtl/coef_lane.sv
module coef_lane
   import coef_adapt_pkg::*;
#(
   parameter int   DW    = 16,
   parameter int   SHIFT = 8,
   parameter rnd_e RND   = RND_FLOOR
) (
   input  logic signed [DW-1:0] w_cur,
   input  logic signed [DW-1:0] x_smp,
   input  logic signed [DW-1:0] err_smp,
   input  logic                 active,
   output logic signed [DW-1:0] w_nxt
);
   localparam int PW = 2 * DW;
   localparam int SW = PW + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] biased;
   logic signed [PW-1:0] step;
   logic signed [SW-1:0] sum;
   logic                 fits;

   assign prod = x_smp * err_smp;

   if (RND == RND_NEAREST && SHIFT > 0) begin : g_near
      localparam logic signed [PW-1:0] HALF = PW'(1) << (SHIFT - 1);
      assign biased = prod + HALF;
   end else begin : g_floor
      assign biased = prod;
   end

   assign step = biased >>> SHIFT;
   assign sum  = SW'(w_cur) + SW'(step);
   assign fits = (&sum[SW-1:DW-1]) | ~(|sum[SW-1:DW-1]);

   always_comb begin
      if (!active) begin
         w_nxt = w_cur;
      end else if (fits) begin
         w_nxt = sum[DW-1:0];
      end else if (sum[SW-1]) begin
         w_nxt = {1'b1, {(DW-1){1'b0}}};
      end else begin
         w_nxt = {1'b0, {(DW-1){1'b1}}};
      end
   end
endmodule

// File: rtl/coef_commit.sv
module coef_commit #(
   parameter int LANES = 8,
   parameter int DW    = 16,
   parameter int OW    = $clog2(LANES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic                  en,
   input  logic [OW-1:0]         order,
   input  logic [LANES*DW-1:0]   staged,
   output logic [LANES-1:0]      we,
   output logic [LANES*DW-1:0]   wdata,
   output logic                  done
);
   logic [LANES-1:0] mask;
   logic             take;
   logic             pend;

   coef_order_mask #(.LANES(LANES), .OW(OW)) u_mask (
      .order (order),
      .mask  (mask)
   );

   assign take = go & en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we    <= '0;
         wdata <= '0;
         pend  <= 1'b0;
         done  <= 1'b0;
      end else begin
         we   <= take ? mask : '0;
         pend <= take;
         done <= pend;
         if (take) begin
            wdata <= staged;
         end
      end
   end
endmodule

// File: rtl/coef_adapt_array.sv
module coef_adapt_array
   import coef_adapt_pkg::*;
#(
   parameter int   LANES = 8,
   parameter int   DW    = 16,
   parameter int   SHIFT = 8,
   parameter rnd_e RND   = RND_FLOOR,
   parameter int   OW    = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mac_go,
   input  logic                mac_en,
   input  logic [OW-1:0]       mac_order,
   input  logic [LANES*DW-1:0] x_win,
   input  logic [DW-1:0]       err_smp,
   input  logic [LANES*DW-1:0] w_cur,
   output logic [LANES*DW-1:0] w_new,
   output logic                upd_done,
   input  logic                wr_go,
   input  logic                wr_en,
   input  logic [OW-1:0]       wr_order,
   output logic [LANES-1:0]    wbuf_we,
   output logic [LANES*DW-1:0] wbuf_wdata,
   output logic                wr_done
);
   localparam int VW = LANES * DW;

   if (LANES < 1) begin : g_bad_lanes
      $error("coef_adapt_array: LANES must be at least 1");
   end
   if (DW < 2) begin : g_bad_dw
      $error("coef_adapt_array: DW must be at least 2");
   end
   if (SHIFT < 0 || SHIFT >= 2 * DW) begin : g_bad_shift
      $error("coef_adapt_array: SHIFT out of range");
   end
   if (OW < $clog2(LANES + 1)) begin : g_bad_ow
      $error("coef_adapt_array: OW too narrow for LANES");
   end

   logic [LANES-1:0] act;
   logic [VW-1:0]    lane_nxt;
   logic             upd_take;

   coef_order_mask #(.LANES(LANES), .OW(OW)) u_act (
      .order (mac_order),
      .mask  (act)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      coef_lane #(.DW(DW), .SHIFT(SHIFT), .RND(RND)) u_lane (
         .w_cur   (w_cur[g*DW +: DW]),
         .x_smp   (x_win[g*DW +: DW]),
         .err_smp (err_smp),
         .active  (act[g]),
         .w_nxt   (lane_nxt[g*DW +: DW])
      );
   end

   assign upd_take = mac_go & mac_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_new    <= '0;
         upd_done <= 1'b0;
      end else begin
         upd_done <= upd_take;
         if (upd_take) begin
            w_new <= lane_nxt;
         end
      end
   end

   coef_commit #(.LANES(LANES), .DW(DW), .OW(OW)) u_commit (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (wr_go),
      .en     (wr_en),
      .order  (wr_order),
      .staged (w_new),
      .we     (wbuf_we),
      .wdata  (wbuf_wdata),
      .done   (wr_done)
   );
endmodule

// File: rtl/coef_adapt_array_chk.sv
module coef_adapt_array_chk #(
   parameter int LANES = 8,
   parameter int DW    = 16,
   parameter int OW    = $clog2(LANES + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mac_go,
   input logic                mac_en,
   input logic                wr_go,
   input logic                wr_en,
   input logic [LANES*DW-1:0] w_new,
   input logic                upd_done,
   input logic [LANES-1:0]    wbuf_we,
   input logic [LANES*DW-1:0] wbuf_wdata,
   input logic                wr_done
);
   // R2
   upd_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> $past(mac_go && mac_en));

   // R5
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mac_go && mac_en) |-> $stable(w_new));

   // R6
   strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|wbuf_we) |-> $past(wr_go && wr_en));

   // R6
   strobe_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wbuf_we & (wbuf_we + 1'b1)) == '0));

   // R7
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_go && wr_en) |-> $stable(wbuf_wdata));

   // R9
   wr_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $past(wr_go && wr_en, 2));
endmodule

bind coef_adapt_array coef_adapt_array_chk #(.LANES(LANES), .DW(DW), .OW(OW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mac_go     (mac_go),
   .mac_en     (mac_en),
   .wr_go      (wr_go),
   .wr_en      (wr_en),
   .w_new      (w_new),
   .upd_done   (upd_done),
   .wbuf_we    (wbuf_we),
   .wbuf_wdata (wbuf_wdata),
   .wr_done    (wr_done)
);

// File: tb/coef_adapt_array_tb.sv
module coef_adapt_array_tb;
   localparam int LANES = 4;
   localparam int DW    = 16;
   localparam int SHIFT = 8;
   localparam int OW    = $clog2(LANES + 1);
   localparam int VW    = LANES * DW;
   localparam int NV    = 6;

   typedef struct packed {
      logic [OW-1:0] ord;
      logic [DW-1:0] err;
      logic [VW-1:0] x;
      logic [VW-1:0] w;
   } vec_t;

   // lanes written {lane3, lane2, lane1, lane0}
   localparam vec_t VEC [NV] = '{
      '{ord: 3'd4, err: 16'h0100, x: {16'h0064, 16'hFF38, 16'h012C, 16'hFFFB}, w: {16'd10, 16'd20, 16'd30, 16'd40}},
      '{ord: 3'd2, err: 16'hFFFD, x: {16'h1000, 16'h2000, 16'h0800, 16'hF000}, w: {16'd1, 16'd2, 16'd3, 16'd4}},
      '{ord: 3'd7, err: 16'h7FFF, x: {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF}, w: {16'h7000, 16'h7000, 16'h7000, 16'h7000}},
      '{ord: 3'd4, err: 16'h7FFF, x: {16'h8000, 16'h8000, 16'h8000, 16'h8000}, w: {16'h8100, 16'h8100, 16'h8100, 16'h8100}},
      '{ord: 3'd0, err: 16'h4000, x: {16'h4000, 16'h4000, 16'h4000, 16'h4000}, w: {16'h0011, 16'h0022, 16'h0033, 16'h0044}},
      '{ord: 3'd3, err: 16'hFFFF, x: {16'h0001, 16'h0001, 16'h0001, 16'h0001}, w: {16'd5, 16'd5, 16'd5, 16'd5}}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mac_go = 1'b0, mac_en = 1'b0, wr_go = 1'b0, wr_en = 1'b0;
   logic [OW-1:0] mac_order = '0, wr_order = '0;
   logic [VW-1:0] x_win = '0, w_cur = '0;
   logic [DW-1:0] err_smp = '0;
   logic [VW-1:0] w_new, wbuf_wdata;
   logic          upd_done, wr_done;
   logic [LANES-1:0] wbuf_we;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   coef_adapt_array #(.LANES(LANES), .DW(DW), .SHIFT(SHIFT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .mac_go(mac_go), .mac_en(mac_en), .mac_order(mac_order),
      .x_win(x_win), .err_smp(err_smp), .w_cur(w_cur),
      .w_new(w_new), .upd_done(upd_done),
      .wr_go(wr_go), .wr_en(wr_en), .wr_order(wr_order),
      .wbuf_we(wbuf_we), .wbuf_wdata(wbuf_wdata), .wr_done(wr_done)
   );

   task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] lane_ref(input logic [DW-1:0] w, input logic [DW-1:0] x,
                                              input logic [DW-1:0] e, input bit on);
      longint p, s;
      if (!on) return w;
      p = longint'($signed(x)) * longint'($signed(e));
      p = p >>> SHIFT;
      s = longint'($signed(w)) + p;
      if (s > 32767)  s = 32767;
      if (s < -32768) s = -32768;
      return s[DW-1:0];
   endfunction

   function automatic logic [VW-1:0] vec_ref(input vec_t v);
      logic [VW-1:0] r;
      for (int i = 0; i < LANES; i++)
         r[i*DW +: DW] = lane_ref(v.w[i*DW +: DW], v.x[i*DW +: DW], v.err, i < int'(v.ord));
      return r;
   endfunction

   function automatic logic [LANES-1:0] mask_ref(input logic [OW-1:0] o);
      logic [LANES-1:0] m;
      for (int i = 0; i < LANES; i++) m[i] = (i < int'(o));
      return m;
   endfunction

   task automatic load(input vec_t v);
      mac_order = v.ord; err_smp = v.err; x_win = v.x; w_cur = v.w;
   endtask

   initial begin : watchdog
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      logic [VW-1:0] prev, cur;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(w_new == '0 && !upd_done && !wr_done && wbuf_we == '0, "R1 reset", w_new, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(w_new == '0 && !upd_done && !wr_done && wbuf_we == '0, "R1 after release", w_new, '0);

      prev = '0;
      for (int k = 0; k < NV; k++) begin
         load(VEC[k]);
         mac_en = 1'b1; mac_go = 1'b1;
         @(negedge clk);
         mac_go = 1'b0;
         cur = vec_ref(VEC[k]);
         // R2 R3 R4 update result and pulse
         chk(upd_done == 1'b1, "R2 upd_done", VW'(upd_done), VW'(1));
         chk(w_new == cur, "R2/R3/R4 weights", w_new, cur);
         @(negedge clk);
         // R9 single-cycle pulse
         chk(upd_done == 1'b0, "R9 upd_done width", VW'(upd_done), '0);
         wr_order = VEC[k].ord; wr_en = 1'b1; wr_go = 1'b1;
         @(negedge clk);
         wr_go = 1'b0;
         // R6 strobes and data
         chk(wbuf_we == mask_ref(VEC[k].ord), "R6 strobes", VW'(wbuf_we), VW'(mask_ref(VEC[k].ord)));
         chk(wbuf_wdata == cur, "R6 write data", wbuf_wdata, cur);
         chk(wr_done == 1'b0, "R6 done timing", VW'(wr_done), '0);
         @(negedge clk);
         chk(wbuf_we == '0 && wr_done == 1'b1, "R6 done pulse", {wbuf_we, wr_done}, VW'(1));
         @(negedge clk);
         chk(wr_done == 1'b0, "R9 wr_done width", VW'(wr_done), '0);
         prev = cur;
      end

      // R5 update command without enable
      load(VEC[0]);
      mac_en = 1'b0; mac_go = 1'b1;
      @(negedge clk);
      mac_go = 1'b0;
      chk(upd_done == 1'b0, "R5 no pulse", VW'(upd_done), '0);
      chk(w_new == prev, "R5 weights kept", w_new, prev);

      // R7 write-back without enable
      wr_order = 3'd4; wr_en = 1'b0; wr_go = 1'b1;
      @(negedge clk);
      wr_go = 1'b0;
      chk(wbuf_we == '0, "R7 no strobe", VW'(wbuf_we), '0);
      @(negedge clk);
      chk(wr_done == 1'b0, "R7 no done", VW'(wr_done), '0);

      // R8 both commands on one edge
      load(VEC[0]);
      mac_en = 1'b1; mac_go = 1'b1; wr_en = 1'b1; wr_order = 3'd4; wr_go = 1'b1;
      @(negedge clk);
      mac_go = 1'b0; wr_go = 1'b0;
      chk(wbuf_wdata == prev, "R8 old data written", wbuf_wdata, prev);
      chk(w_new == vec_ref(VEC[0]), "R8 new data staged", w_new, vec_ref(VEC[0]));
      chk(upd_done == 1'b1 && wbuf_we == 4'hF, "R8 both fired", {wbuf_we, upd_done}, {4'hF, 1'b1});
      @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule